// File: doc/BRIEF.md
# Dual-Source Thermal Threshold Monitor

The block watches two temperature channels whose readings arrive as 12-bit codes from an external converter. A host sets it up through a small 32-bit register bus. Once running, the block asks for a conversion on a programmable period and shortens that period while either channel sits at or above its warning level. Each accepted reading is stored and checked against three limits per channel: a warning level, a shutdown level and a low level. Crossings of the warning and shutdown levels must persist for a programmable number of consecutive readings before they count.

Detected events set sticky pending bits that software clears by writing ones. An interrupt line combines the pending bits with their enables. A confirmed shutdown crossing is latched until reset. It drives a reset-request output, a GPIO output, or both, as selected per channel, at a programmable active level.

Register layout (byte addresses):
- 0x00 control: bit 0 run, bits 2:1 channel enables, bit 3 shutdown polarity (1 = active high), bits 5:4 low-limit enables.
- 0x04 enables: bits 1:0 warning irq, bits 3:2 low irq, bits 5:4 shutdown-to-reset routing, bits 7:6 shutdown-to-GPIO routing, bit 8 conversion-done irq.
- 0x08 pending (write 1 to clear): bits 1:0 warning, bits 3:2 low, bits 5:4 shutdown, bit 8 conversion done.
- 0x0C normal period.
- 0x10 hot period.
- 0x14 debounce: bits 7:0 warning count, bits 15:8 shutdown count.
- 0x18 and 0x1C: last reading of channels 0 and 1 (read-only).
- 0x20 and 0x24: warning limits.
- 0x28 and 0x2C: shutdown limits.
- 0x30 and 0x34: low limits.

Top module: `thermal_guard`

## Requirements
- R1: After reset every register reads 0, and both shutdown outputs sit at their idle level, which is high because the polarity bit is 0. Writable registers read back what was written, masked to their field widths.
- R2: A reading is accepted only on a cycle with `adc_valid` high and run (control bit 0) set. Channel i's stored reading updates only if its enable (control bit 1+i) is set. Otherwise it is unchanged.
- R3: While run is set, `sample_req` pulses whenever the period counter is 0, and the counter then reloads. With reload value P, pulses are P+1 cycles apart. While run is clear, the counter is held at 0 and there are no pulses.
- R4: The reload value is the hot period (0x10) while either channel's last accepted reading is at or above its warning limit. Otherwise it is the normal period (0x0C).
- R5: A channel's warning pending bit is set when its count of consecutive accepted readings at or above the warning limit reaches the warning debounce count. A count of 0 acts as 1. Any reading below the limit resets the count to 0.
- R6: The shutdown pending bit follows the same debounce rule, using the shutdown limit and shutdown count. A confirmed shutdown also sets a per-channel latch that only reset clears.
- R7: `shut_rst` is active when any latched channel has its reset routing bit set. `shut_gpio` is active when any latched channel has its GPIO routing bit set. The active level is high when the polarity bit is 1 and low when it is 0.
- R8: With the channel's low enable set, an accepted reading at or below its low limit sets the low pending bit at once.
- R9: Writing 1 to a pending bit clears it. A set in the same cycle wins over the clear. Every accepted reading sets the conversion-done bit.
- R10: `irq` is the OR of each pending bit ANDed with its enable, for the warning, low and conversion-done bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| adc_valid | input | 1 | Both codes are valid this cycle |
| adc_code0 | input | 12 | Channel 0 code |
| adc_code1 | input | 12 | Channel 1 code |
| sample_req | output | 1 | Conversion request pulse |
| irq | output | 1 | Interrupt request |
| shut_rst | output | 1 | Shutdown request toward the reset path |
| shut_gpio | output | 1 | Shutdown request toward a GPIO pin |

## Verification
The assertions assume three things about the inputs. `adc_valid` lasts one cycle per reading. Codes are stable while it is high. At most one bus write arrives per cycle. The stimulus drives every input on the falling edge and raises the valid strobe and write strobe for exactly one cycle each. It keeps the periods short, so several reload cycles of both periods fall inside each phase of the test. The reference model follows the same accept rule, and the outputs are compared with it on every clock.

// File: rtl/thermal_guard.sv
module thermal_guard #(
  parameter int CW = 12,
  parameter int DW = 8,
  parameter int PW = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        adc_valid,
  input  logic [11:0] adc_code0,
  input  logic [11:0] adc_code1,
  output logic        sample_req,
  output logic        irq,
  output logic        shut_rst,
  output logic        shut_gpio
);
  localparam logic [7:0] A_CTRL = 8'h00, A_IEN = 8'h04, A_PEND = 8'h08, A_PER = 8'h0C,
                         A_PERH = 8'h10, A_DEB = 8'h14, A_SMP0 = 8'h18, A_SMP1 = 8'h1C,
                         A_WRN0 = 8'h20, A_WRN1 = 8'h24, A_SHT0 = 8'h28, A_SHT1 = 8'h2C,
                         A_LOW0 = 8'h30, A_LOW1 = 8'h34;
  localparam logic [8:0] PMASK = 9'h13F;
  localparam logic [8:0] IMASK = 9'h10F;
  localparam logic [DW-1:0] DMAX = '1;

  logic [5:0]    ctrl;
  logic [8:0]    ien, pend, setv, clr;
  logic [PW-1:0] per, perh, cnt;
  logic [DW-1:0] debw, debs;
  logic [CW-1:0] smp [2];
  logic [CW-1:0] thw [2];
  logic [CW-1:0] ths [2];
  logic [CW-1:0] thl [2];
  logic [CW-1:0] code [2];
  logic [DW-1:0] wc [2];
  logic [DW-1:0] sc [2];
  logic [DW-1:0] wc_n [2];
  logic [DW-1:0] sc_n [2];
  logic [1:0]    hot, hit, take, hi_set, sh_set, lo_set, over_w, over_s;
  logic          acc, act_r, act_g;

  assign code[0] = adc_code0;
  assign code[1] = adc_code1;
  assign acc = adc_valid && ctrl[0];

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      take[i]   = acc && ctrl[1+i];
      over_w[i] = code[i] >= thw[i];
      over_s[i] = code[i] >= ths[i];
      wc_n[i]   = over_w[i] ? ((wc[i] == DMAX) ? wc[i] : wc[i] + DW'(1)) : '0;
      sc_n[i]   = over_s[i] ? ((sc[i] == DMAX) ? sc[i] : sc[i] + DW'(1)) : '0;
      hi_set[i] = take[i] && over_w[i] && wc_n[i] >= debw;
      sh_set[i] = take[i] && over_s[i] && sc_n[i] >= debs;
      lo_set[i] = take[i] && ctrl[4+i] && code[i] <= thl[i];
    end
    setv = {acc, 2'b00, sh_set, lo_set, hi_set};
    clr  = (bus_wr && bus_addr == A_PEND) ? bus_wdata[8:0] : 9'h000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; ien <= '0; pend <= '0; per <= '0; perh <= '0; cnt <= '0;
      debw <= '0; debs <= '0; hot <= '0; hit <= '0;
      for (int i = 0; i < 2; i++) begin
        smp[i] <= '0; thw[i] <= '0; ths[i] <= '0; thl[i] <= '0; wc[i] <= '0; sc[i] <= '0;
      end
    end else begin
      if (!ctrl[0])        cnt <= '0;
      else if (cnt == '0)  cnt <= (|hot) ? perh : per;
      else                 cnt <= cnt - PW'(1);
      for (int i = 0; i < 2; i++) begin
        if (take[i]) begin
          smp[i] <= code[i];
          hot[i] <= over_w[i];
          wc[i]  <= wc_n[i];
          sc[i]  <= sc_n[i];
        end
        if (sh_set[i]) hit[i] <= 1'b1;
      end
      pend <= ((pend & ~clr) | setv) & PMASK;
      if (bus_wr) begin
        case (bus_addr)
          A_CTRL: ctrl <= bus_wdata[5:0];
          A_IEN:  ien  <= bus_wdata[8:0];
          A_PER:  per  <= bus_wdata[PW-1:0];
          A_PERH: perh <= bus_wdata[PW-1:0];
          A_DEB:  begin debw <= bus_wdata[DW-1:0]; debs <= bus_wdata[2*DW-1:DW]; end
          A_WRN0: thw[0] <= bus_wdata[CW-1:0];
          A_WRN1: thw[1] <= bus_wdata[CW-1:0];
          A_SHT0: ths[0] <= bus_wdata[CW-1:0];
          A_SHT1: ths[1] <= bus_wdata[CW-1:0];
          A_LOW0: thl[0] <= bus_wdata[CW-1:0];
          A_LOW1: thl[1] <= bus_wdata[CW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = 32'(ctrl);
      A_IEN:   bus_rdata = 32'(ien);
      A_PEND:  bus_rdata = 32'(pend);
      A_PER:   bus_rdata = 32'(per);
      A_PERH:  bus_rdata = 32'(perh);
      A_DEB:   bus_rdata = 32'({debs, debw});
      A_SMP0:  bus_rdata = 32'(smp[0]);
      A_SMP1:  bus_rdata = 32'(smp[1]);
      A_WRN0:  bus_rdata = 32'(thw[0]);
      A_WRN1:  bus_rdata = 32'(thw[1]);
      A_SHT0:  bus_rdata = 32'(ths[0]);
      A_SHT1:  bus_rdata = 32'(ths[1]);
      A_LOW0:  bus_rdata = 32'(thl[0]);
      A_LOW1:  bus_rdata = 32'(thl[1]);
      default: bus_rdata = '0;
    endcase
  end

  assign act_r      = |(hit & ien[5:4]);
  assign act_g      = |(hit & ien[7:6]);
  assign shut_rst   = ctrl[3] ? act_r : ~act_r;
  assign shut_gpio  = ctrl[3] ? act_g : ~act_g;
  assign irq        = |(pend & ien & IMASK);
  assign sample_req = ctrl[0] && (cnt == '0);

  p_smp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(adc_valid && ctrl[0]) |=> $stable(smp[0]) && $stable(smp[1]));
  p_req_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req && ((|hot) ? perh : per) != '0 |=> !sample_req);
  p_hi_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[0]) |-> $past(adc_valid && ctrl[0] && ctrl[1]));
  p_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] || hit[1] |=> (hit & $past(hit)) == $past(hit));
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit == 2'b00 |-> shut_rst == !ctrl[3] && shut_gpio == !ctrl[3]);
  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend != 9'h000);
endmodule

// File: tb/sim_thermal_guard.sv
`timescale 1ns/1ps
module sim_thermal_guard;
  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0;
  logic bus_wr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic adc_valid = 0;
  logic [11:0] adc_code0 = 0, adc_code1 = 0;
  logic sample_req, irq, shut_rst, shut_gpio;
  int errors = 0, checks = 0;
  bit done = 0;

  localparam logic [7:0] A_CTRL = 8'h00, A_IEN = 8'h04, A_PEND = 8'h08, A_PER = 8'h0C,
    A_PERH = 8'h10, A_DEB = 8'h14, A_SMP0 = 8'h18, A_SMP1 = 8'h1C, A_WRN0 = 8'h20,
    A_WRN1 = 8'h24, A_SHT0 = 8'h28, A_SHT1 = 8'h2C, A_LOW0 = 8'h30, A_LOW1 = 8'h34;

  always #2 clk = ~clk;

  thermal_guard u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_valid(adc_valid),
    .adc_code0(adc_code0), .adc_code1(adc_code1), .sample_req(sample_req),
    .irq(irq), .shut_rst(shut_rst), .shut_gpio(shut_gpio));

  int m_ctrl, m_ien, m_pend, m_per, m_perh, m_debw, m_debs, m_cnt;
  int m_smp[2], m_thw[2], m_ths[2], m_thl[2], m_wc[2], m_sc[2];
  bit m_hot[2], m_hit[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_ien = 0; m_pend = 0; m_per = 0; m_perh = 0; m_debw = 0; m_debs = 0; m_cnt = 0;
      for (int i = 0; i < 2; i++) begin
        m_smp[i] = 0; m_thw[i] = 0; m_ths[i] = 0; m_thl[i] = 0;
        m_wc[i] = 0; m_sc[i] = 0; m_hot[i] = 0; m_hit[i] = 0;
      end
    end else begin
      int setb, clrb, code;
      setb = 0;
      if (m_ctrl[0]) begin
        if (m_cnt == 0) m_cnt = (m_hot[0] || m_hot[1]) ? m_perh : m_per;
        else m_cnt--;
      end else m_cnt = 0;
      if (m_ctrl[0] && adc_valid) begin
        setb = 'h100;
        for (int i = 0; i < 2; i++) if (m_ctrl[1+i]) begin
          code = (i == 1) ? adc_code1 : adc_code0;
          m_smp[i] = code;
          m_hot[i] = code >= m_thw[i];
          if (code >= m_thw[i]) begin
            if (m_wc[i] < 255) m_wc[i]++;
            if (m_wc[i] >= m_debw) setb |= 1 << i;
          end else m_wc[i] = 0;
          if (code >= m_ths[i]) begin
            if (m_sc[i] < 255) m_sc[i]++;
            if (m_sc[i] >= m_debs) begin setb |= 1 << (4+i); m_hit[i] = 1; end
          end else m_sc[i] = 0;
          if (m_ctrl[4+i] && code <= m_thl[i]) setb |= 1 << (2+i);
        end
      end
      clrb = (bus_wr && bus_addr == A_PEND) ? int'(bus_wdata[8:0]) : 0;
      m_pend = ((m_pend & ~clrb) | setb) & 'h13F;
      if (bus_wr) case (bus_addr)
        A_CTRL: m_ctrl = int'(bus_wdata[5:0]);
        A_IEN:  m_ien  = int'(bus_wdata[8:0]);
        A_PER:  m_per  = int'(bus_wdata);
        A_PERH: m_perh = int'(bus_wdata);
        A_DEB:  begin m_debw = int'(bus_wdata[7:0]); m_debs = int'(bus_wdata[15:8]); end
        A_WRN0: m_thw[0] = int'(bus_wdata[11:0]);
        A_WRN1: m_thw[1] = int'(bus_wdata[11:0]);
        A_SHT0: m_ths[0] = int'(bus_wdata[11:0]);
        A_SHT1: m_ths[1] = int'(bus_wdata[11:0]);
        A_LOW0: m_thl[0] = int'(bus_wdata[11:0]);
        A_LOW1: m_thl[1] = int'(bus_wdata[11:0]);
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit e_req, e_irq, ar, ag, e_rst, e_gpio;
    e_req  = m_ctrl[0] && m_cnt == 0;
    e_irq  = (m_pend & m_ien & 'h10F) != 0;
    ar     = (m_hit[0] && m_ien[4]) || (m_hit[1] && m_ien[5]);
    ag     = (m_hit[0] && m_ien[6]) || (m_hit[1] && m_ien[7]);
    e_rst  = m_ctrl[3] ? ar : !ar;
    e_gpio = m_ctrl[3] ? ag : !ag;
    chk(sample_req == e_req, "R3/R4 sample_req", sample_req, e_req);
    chk(irq == e_irq, "R10 irq", irq, e_irq);
    chk(shut_rst == e_rst, "R7 shut_rst", shut_rst, e_rst);
    chk(shut_gpio == e_gpio, "R7 shut_gpio", shut_gpio, e_gpio);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic smp(input logic [11:0] c0, input logic [11:0] c1);
    @(negedge clk); adc_code0 = c0; adc_code1 = c1; adc_valid = 1;
    @(negedge clk); adc_valid = 0;
  endtask

  task automatic rd(input logic [7:0] a, input longint exp, input string tag);
    @(negedge clk); bus_addr = a; #1;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(A_PEND, 0, "R1 pend reset");
    rd(A_CTRL, 0, "R1 ctrl reset");
    chk(shut_rst == 1 && shut_gpio == 1, "R1 idle shut outputs", {shut_rst, shut_gpio}, 2'b11);
    wr(A_PER, 5); wr(A_PERH, 2); wr(A_DEB, (2 << 8) | 3);
    wr(A_WRN0, 'h200); wr(A_WRN1, 'h300); wr(A_SHT0, 'h280); wr(A_SHT1, 'h380);
    wr(A_LOW0, 'h50); wr(A_LOW1, 'h60); wr(A_IEN, 'h19F);
    rd(A_WRN1, 'h300, "R1 readback");
    rd(A_DEB, 'h203, "R1 debounce readback");
    // R2 not running: reading ignored
    smp('h400, 'h400);
    rd(A_SMP0, 0, "R2 no capture when stopped");
    rd(A_PEND, 0, "R2 no eoc when stopped");
    // R3 normal period
    wr(A_CTRL, 'h3);
    repeat (20) @(negedge clk);
    // R2 channel 1 disabled
    smp('h210, 'h390);
    rd(A_SMP0, 'h210, "R2 channel 0 captured");
    rd(A_SMP1, 0, "R2 disabled channel 1 unchanged");
    // R5 debounce reset by low reading
    smp('h210, 0); smp('h100, 0);
    @(negedge clk); bus_addr = A_PEND; #1;
    chk(bus_rdata[0] == 0, "R5 broken run no warning", bus_rdata[0], 0);
    smp('h210, 0); smp('h210, 0);
    @(negedge clk); bus_addr = A_PEND; #1;
    chk(bus_rdata[0] == 0, "R5 two of three no warning", bus_rdata[0], 0);
    smp('h210, 0);
    @(negedge clk); bus_addr = A_PEND; #1;
    chk(bus_rdata[0] == 1, "R5 warning after three", bus_rdata[0], 1);
    // R4 hot period in effect
    repeat (15) @(negedge clk);
    // R9 clear
    wr(A_PEND, 'h1FF);
    rd(A_PEND, 0, "R9 write one clears");
    // R8 low limit
    wr(A_CTRL, 'h37);
    smp('h40, 'h40);
    @(negedge clk); bus_addr = A_PEND; #1;
    chk(bus_rdata[3:2] == 2'b11, "R8 low pending", bus_rdata[3:2], 3);
    repeat (12) @(negedge clk);
    // R6 shutdown with debounce 2
    smp('h290, 'h390);
    @(negedge clk); bus_addr = A_PEND; #1;
    chk(bus_rdata[5:4] == 0, "R6 one reading no shutdown", bus_rdata[5:4], 0);
    smp('h290, 'h390);
    @(negedge clk); bus_addr = A_PEND; #1;
    chk(bus_rdata[5:4] == 2'b11, "R6 shutdown pending", bus_rdata[5:4], 3);
    chk(shut_rst == 0 && shut_gpio == 0, "R7 active low outputs", {shut_rst, shut_gpio}, 0);
    wr(A_PEND, 'h1FF); smp('h10, 'h10);
    repeat (3) @(negedge clk);
    chk(shut_rst == 0, "R6 latch survives clear and cool reading", shut_rst, 0);
    // R7 polarity and routing
    wr(A_CTRL, 'h3F);
    @(negedge clk);
    chk(shut_rst == 1 && shut_gpio == 1, "R7 active high outputs", {shut_rst, shut_gpio}, 3);
    wr(A_IEN, 'h10F);
    @(negedge clk);
    chk(shut_rst == 0 && shut_gpio == 0, "R7 unrouted outputs inactive", {shut_rst, shut_gpio}, 0);
    // R5 zero debounce acts as one
    wr(A_DEB, 0); wr(A_PEND, 'h1FF);
    smp('h210, 0);
    @(negedge clk); bus_addr = A_PEND; #1;
    chk(bus_rdata[0] == 1, "R5 zero debounce immediate", bus_rdata[0], 1);
    // R9 set wins over clear in same cycle
    wr(A_PEND, 'h1FF);
    @(negedge clk);
    bus_addr = A_PEND; bus_wdata = 'h100; bus_wr = 1; adc_code0 = 'h10; adc_code1 = 'h10; adc_valid = 1;
    @(negedge clk); bus_wr = 0; adc_valid = 0; #1;
    chk(bus_rdata[8] == 1, "R9 set beats clear", bus_rdata[8], 1);
    // R10 masking
    wr(A_IEN, 0);
    @(negedge clk);
    chk(irq == 0, "R10 masked irq", irq, 0);
    wr(A_IEN, 'h100);
    @(negedge clk);
    chk(irq == 1, "R10 eoc irq", irq, 1);
    // R3 stop clears request
    wr(A_CTRL, 0);
    repeat (8) @(negedge clk);
    chk(sample_req == 0, "R3 stopped no request", sample_req, 0);
    finish_run();
  end
endmodule